// File: doc/BRIEF.md
# Spawn-Join Thread ID Dispatcher

This block runs one parallel region at a time on a group of thread control units (TCUs). A serial master starts the region with a thread count and a base offset. The block gives every TCU a starting thread ID. When a TCU finishes a thread, it asks for another ID. The block hands these out from one shared counter, so a TCU that finishes early picks up more work. A TCU whose granted ID is at or above the region's limit becomes done and stops.

A fork request raises the limit while the region is running, which makes IDs past the original limit valid. When every TCU is done, the block closes the region and gives control back to TCU 0, which runs serial code whenever no region is open.

Top module: `spawn_dispatch`

## Requirements
- R1: A spawn request accepted while idle sets busy in the next cycle. In that cycle TCU i holds thread ID offset + i, and the limit becomes offset + count.
- R2: A TCU whose starting ID is at or above the limit (that is, i >= count) starts done, with its tcu_active bit at 0.
- R3: An active TCU that raises id_req gets the next ID from the shared counter in the next cycle. The counter starts at offset + NTCU. The TCU stays active only if the new ID is below the limit.
- R4: Several requests in the same cycle receive distinct consecutive IDs, with the lower TCU index taking the lower ID.
- R5: A fork request raises the limit by fork_amount. The raised limit already applies to requests made in the same cycle.
- R6: When busy is high and no TCU is active, busy falls at the next edge and join_done is high for exactly that one following cycle.
- R7: A spawn request made while busy has no effect on IDs, the limit or the counter.
- R8: serial_run (TCU 0 executing serial code) is high exactly when busy is low.
- R9: Over a complete region, each ID in [offset, offset + count) is run exactly once.
- R10: id_req from a done TCU is ignored and uses up no ID. A done TCU stays done until the next spawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spawn_req | input | 1 | Start a parallel region |
| spawn_count | input | IDW | Number of threads in the region |
| spawn_offset | input | IDW | First thread ID of the region |
| fork_req | input | 1 | Raise the thread limit this cycle |
| fork_amount | input | IDW | Amount added to the limit by a fork |
| id_req | input | NTCU | Per-TCU request for a new thread ID |
| busy | output | 1 | Parallel region open |
| serial_run | output | 1 | TCU 0 is running serial code |
| join_done | output | 1 | One-cycle pulse when the region closes |
| tcu_active | output | NTCU | TCU holds a valid thread ID |
| tcu_id | output | NTCU*IDW | Current thread ID per TCU, TCU i in bits [i*IDW +: IDW] |

## Verification
A wrong counter value appears on tcu_id one cycle after the next grant. It shows up either as a duplicated or skipped ID in the sum of IDs run over a region, or as a TCU that goes done too early or too late. A wrong limit or a mishandled fork shows up on tcu_active in the grant cycle. A lost active bit shows up as busy falling early: join_done arrives before the expected number of threads has run. Stray spawns and stray requests from done TCUs are caught by the ID that the next legitimate grant returns.

// File: rtl/spawn_dispatch.sv
module spawn_dispatch #(
  parameter int NTCU = 4,
  parameter int IDW  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spawn_req,
  input  logic [IDW-1:0]       spawn_count,
  input  logic [IDW-1:0]       spawn_offset,
  input  logic                 fork_req,
  input  logic [IDW-1:0]       fork_amount,
  input  logic [NTCU-1:0]      id_req,
  output logic                 busy,
  output logic                 serial_run,
  output logic                 join_done,
  output logic [NTCU-1:0]      tcu_active,
  output logic [NTCU*IDW-1:0]  tcu_id
);
  logic [IDW-1:0]  bound, next_id, bound_eff, taken;
  logic [IDW-1:0]  new_id [NTCU];
  logic [NTCU-1:0] grant;

  assign serial_run = !busy;
  assign grant      = id_req & tcu_active & {NTCU{busy}};
  assign bound_eff  = bound + ((busy && fork_req) ? fork_amount : '0);

  always_comb begin
    taken = '0;
    for (int i = 0; i < NTCU; i++) begin
      new_id[i] = next_id + taken;
      if (grant[i]) taken = taken + IDW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      join_done  <= 1'b0;
      bound      <= '0;
      next_id    <= '0;
      tcu_active <= '0;
      tcu_id     <= '0;
    end else begin
      join_done <= 1'b0;
      if (!busy) begin
        if (spawn_req) begin
          busy    <= 1'b1;
          bound   <= spawn_offset + spawn_count;
          next_id <= spawn_offset + IDW'(NTCU);
          for (int i = 0; i < NTCU; i++) begin
            tcu_id[i*IDW +: IDW] <= spawn_offset + IDW'(i);
            tcu_active[i]        <= IDW'(i) < spawn_count;
          end
        end
      end else if (tcu_active == '0) begin
        busy      <= 1'b0;
        join_done <= 1'b1;
      end else begin
        bound   <= bound_eff;
        next_id <= next_id + taken;
        for (int i = 0; i < NTCU; i++) begin
          if (grant[i]) begin
            tcu_id[i*IDW +: IDW] <= new_id[i];
            tcu_active[i]        <= new_id[i] < bound_eff;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spawn_dispatch_chk.sv
module spawn_dispatch_chk #(
  parameter int NTCU = 4,
  parameter int IDW  = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                spawn_req,
  input logic [NTCU-1:0]     id_req,
  input logic                busy,
  input logic                join_done,
  input logic [NTCU-1:0]     tcu_active,
  input logic [NTCU*IDW-1:0] tcu_id
);
  p_join_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    join_done |-> !busy);
  p_join_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    join_done |=> !join_done);
  p_fall_join_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> join_done);
  p_spawn_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && spawn_req) |=> busy);
  p_ignore_spawn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && spawn_req && id_req == '0) |=> $stable(tcu_id));
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ((tcu_active & ~$past(tcu_active)) == '0));
endmodule

bind spawn_dispatch spawn_dispatch_chk #(.NTCU(NTCU), .IDW(IDW)) u_chk (.*);

// File: tb/spawn_dispatch_tb.sv
module spawn_dispatch_tb;
  localparam int NTCU = 4;
  localparam int IDW  = 16;

  logic clk = 0, rst_n = 0, spawn_req = 0, fork_req = 0;
  logic [IDW-1:0] spawn_count = 0, spawn_offset = 0, fork_amount = 0;
  logic [NTCU-1:0] id_req = 0;
  logic busy, serial_run, join_done;
  logic [NTCU-1:0] tcu_active;
  logic [NTCU*IDW-1:0] tcu_id;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spawn_dispatch #(.NTCU(NTCU), .IDW(IDW)) u_dut (.*);

  localparam logic [31:0] VEC [6] = '{
    {16'd0, 16'd5}, {16'd1, 16'd0}, {16'd3, 16'd10},
    {16'd4, 16'd0}, {16'd9, 16'd2}, {16'd17, 16'd100}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int idof(input int i);
    return int'(tcu_id[i*IDW +: IDW]);
  endfunction

  task automatic step;
    @(negedge clk);
  endtask

  task automatic do_spawn(input int cnt, input int off);
    spawn_req = 1; spawn_count = IDW'(cnt); spawn_offset = IDW'(off);
    step;
    spawn_req = 0;
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step; step;
    chk(busy == 0 && tcu_active == 0 && join_done == 0, "R6 reset idle", int'(busy), 0);
    chk(serial_run == 1, "R8 serial at reset", int'(serial_run), 1);
    rst_n = 1;
    step;

    foreach (VEC[v]) begin
      int cnt, off, runs, sum, expsum;
      bit seen;
      cnt = int'(VEC[v][31:16]); off = int'(VEC[v][15:0]);
      runs = 0; sum = 0; seen = 0;
      do_spawn(cnt, off);
      for (int k = 0; k < 200; k++) begin
        if (join_done) begin seen = 1; break; end
        for (int i = 0; i < NTCU; i++)
          if (tcu_active[i]) begin runs++; sum += idof(i); end
        id_req = tcu_active;
        step;
      end
      id_req = 0;
      expsum = cnt * off + cnt * (cnt - 1) / 2;
      chk(seen, "R6 join seen", int'(seen), 1);
      chk(runs == cnt, "R9 thread count", runs, cnt);
      chk(sum == expsum, "R9 id sum", sum, expsum);
      step;
      chk(join_done == 0 && serial_run == 1, "R6 pulse ends", int'(join_done), 0);
    end

    do_spawn(6, 10);
    chk(busy == 1 && serial_run == 0, "R8 busy serial off", int'(serial_run), 0);
    for (int i = 0; i < NTCU; i++)
      chk(idof(i) == 10 + i && tcu_active[i], "R1 initial id", idof(i), 10 + i);
    id_req = 4'b1010; step;
    chk(idof(1) == 14 && tcu_active[1], "R3 grant tcu1", idof(1), 14);
    chk(idof(3) == 15 && tcu_active[3], "R4 order tcu3", idof(3), 15);
    id_req = 4'b0101; step;
    chk(idof(0) == 16 && !tcu_active[0], "R3 past limit tcu0", idof(0), 16);
    chk(idof(2) == 17 && !tcu_active[2], "R4 tcu2", idof(2), 17);
    id_req = 4'b0011; fork_req = 1; fork_amount = 4; step;
    fork_req = 0;
    chk(idof(1) == 18 && tcu_active[1], "R5 fork same cycle", idof(1), 18);
    chk(idof(0) == 16 && !tcu_active[0], "R10 done tcu ignored", idof(0), 16);
    id_req = 0; spawn_req = 1; spawn_count = 2; spawn_offset = 50; step;
    spawn_req = 0;
    chk(idof(3) == 15 && idof(0) == 16 && busy, "R7 spawn ignored ids", idof(3), 15);
    id_req = 4'b1000; step;
    chk(idof(3) == 19 && tcu_active[3], "R7 counter kept", idof(3), 19);
    id_req = 4'b1010; step;
    id_req = 0;
    chk(tcu_active == 0 && busy == 1, "R3 all done", int'(tcu_active), 0);
    step;
    chk(join_done == 1 && busy == 0 && serial_run == 1, "R6 join pulse", int'(join_done), 1);
    step;
    chk(join_done == 0, "R6 one cycle", int'(join_done), 0);

    do_spawn(2, 0);
    chk(tcu_active == 4'b0011, "R2 initial done", int'(tcu_active), 3);
    id_req = 4'b1111; step;
    id_req = 0;
    chk(tcu_active == 0 && idof(0) == 4 && idof(1) == 5, "R10 done reqs free", idof(0), 4);
    step;
    chk(join_done == 1, "R6 join small", int'(join_done), 1);
    step;

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule